// File: doc/BRIEF.md
# Floating-Point Result Rounder

This unit is the last step of a single-precision arithmetic datapath. An adder, multiplier or divider hands it a result that is already normalized: the sign, a biased exponent, a 24-bit significand with its leading one present, and three extra bits from below the last kept position (guard, round, sticky). The unit rounds this value under one of five selectable modes and packs the 32-bit word. It also reports whether rounding lost information and whether the value went beyond the finite range.

The unit is purely combinational. Rounding may carry out of the significand, giving 2.0. The unit then renormalizes the significand to 1.0 and raises the exponent by one. The exponent input is one bit wider than the packed field. An upstream stage can therefore present a value that is already out of range, and the unit saturates it according to the selected mode and the sign. Upstream alignment, normalization and subnormal handling are done elsewhere. The biased exponent presented must be at least 1.

Top module: `fp_round_unit`

## Requirements
- R1: With guard, round and sticky all 0 and a final biased exponent below 255, the packed word is the sign, the exponent's low 8 bits and the significand's low 23 bits, unchanged. The inexact flag is 0.
- R2: Mode code 000 (nearest, ties to even) adds one unit in the last place only when guard is 1 and at least one of LSB, round or sticky is 1.
- R3: Mode code 100 (nearest, ties away from zero) adds one unit in the last place whenever guard is 1.
- R4: Mode code 001 (toward zero) never adds to the significand.
- R5: Mode code 011 (toward +infinity) adds one unit to a positive value when any extra bit is 1. It truncates a negative value.
- R6: Mode code 010 (toward -infinity) adds one unit to a negative value when any extra bit is 1. It truncates a positive value.
- R7: The mode codes 101, 110 and 111 behave exactly like 000.
- R8: If rounding carries the significand to 2.0, the fraction field becomes 0 and the exponent rises by one.
- R9: The inexact output is 1 exactly when any of guard, round or sticky is 1, or when overflow is signalled.
- R10: Overflow is signalled when the final biased exponent is 255 or more. The result is then infinity (exponent 255, fraction 0) when the mode moves away from zero for that sign. That covers codes 000 and 100, positive values under 011, and negative values under 010. In every other case the result is the largest finite value: exponent 254 and an all-ones fraction.
- R11: Bit 31 of the result always equals the input sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_i | input | 1 | Sign of the value, 1 = negative |
| exp_i | input | 9 | Biased exponent, at least 1; may exceed 254 |
| sig_i | input | 24 | Normalized significand, leading one included |
| guard_i | input | 1 | First bit below the LSB |
| round_i | input | 1 | Second bit below the LSB |
| sticky_i | input | 1 | OR of all lower discarded bits |
| mode_i | input | 3 | Rounding mode code |
| result_o | output | 32 | Packed single-precision result |
| inexact_o | output | 1 | Rounded value differs from the exact value |
| overflow_o | output | 1 | Result exceeded the finite range |

## Verification
Two situations are hard to reach from the ports. The first is a rounding carry that crosses into the top exponent code. The second is the saturation choice between infinity and the largest finite value, which depends on both sign and mode. The stimulus sets an all-ones significand at exponent 254 with the guard bit set, which produces overflow through the carry path. It also drives an exponent of 255 directly with no extra bits, which reaches saturation under the truncating modes for both signs. Exact ties against both LSB values separate nearest-even from nearest-away.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [2:0] {
    RM_EVEN = 3'b000,
    RM_ZERO = 3'b001,
    RM_DOWN = 3'b010,
    RM_UP   = 3'b011,
    RM_AWAY = 3'b100
  } rmode_e;
endpackage

// File: rtl/fpr_decide.sv
module fpr_decide
  import fpr_pkg::*;
(
  input  logic       sign,
  input  logic       lsb,
  input  logic       guard,
  input  logic       rnd,
  input  logic       sticky,
  input  logic [2:0] mode,
  output logic       inc,
  output logic       to_inf
);
  logic any_low;

  always_comb begin
    any_low = guard | rnd | sticky;
    inc     = 1'b0;
    to_inf  = 1'b1;
    case (mode)
      RM_ZERO: begin
        inc    = 1'b0;
        to_inf = 1'b0;
      end
      RM_DOWN: begin
        inc    = sign & any_low;
        to_inf = sign;
      end
      RM_UP: begin
        inc    = ~sign & any_low;
        to_inf = ~sign;
      end
      RM_AWAY: begin
        inc    = guard;
        to_inf = 1'b1;
      end
      default: begin
        inc    = guard & (lsb | rnd | sticky);
        to_inf = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/fpr_incr.sv
module fpr_incr #(
  parameter int SIG_W  = 24,
  parameter int EXPI_W = 9
) (
  input  logic [SIG_W-1:0]  sig_in,
  input  logic [EXPI_W-1:0] exp_in,
  input  logic              inc,
  output logic [SIG_W-1:0]  sig_out,
  output logic [EXPI_W:0]   exp_out
);
  logic [SIG_W:0] sum;

  always_comb begin
    sum = {1'b0, sig_in} + {{SIG_W{1'b0}}, inc};
    if (sum[SIG_W]) begin
      sig_out = sum[SIG_W:1];
      exp_out = {1'b0, exp_in} + {{EXPI_W{1'b0}}, 1'b1};
    end else begin
      sig_out = sum[SIG_W-1:0];
      exp_out = {1'b0, exp_in};
    end
  end
endmodule

// File: rtl/fpr_pack.sv
module fpr_pack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    sign,
  input  logic [EXP_W+1:0]        exp_r,
  input  logic [FRAC_W-1:0]       frac,
  input  logic                    to_inf,
  input  logic                    lost,
  output logic [EXP_W+FRAC_W:0]   word,
  output logic                    inexact,
  output logic                    overflow
);
  localparam int                 EXPR_W   = EXP_W + 2;
  localparam logic [EXPR_W-1:0]  TOP_CODE = EXPR_W'((1 << EXP_W) - 1);
  localparam logic [EXP_W-1:0]   ALL_ONE  = {EXP_W{1'b1}};
  localparam logic [EXP_W-1:0]   BIG_EXP  = {{(EXP_W-1){1'b1}}, 1'b0};

  always_comb begin
    overflow = (exp_r >= TOP_CODE);
    inexact  = lost | overflow;
    if (!overflow)
      word = {sign, exp_r[EXP_W-1:0], frac};
    else if (to_inf)
      word = {sign, ALL_ONE, {FRAC_W{1'b0}}};
    else
      word = {sign, BIG_EXP, {FRAC_W{1'b1}}};
  end
endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int EXPI_W = EXP_W + 1,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              sign_i,
  input  logic [EXPI_W-1:0] exp_i,
  input  logic [SIG_W-1:0]  sig_i,
  input  logic              guard_i,
  input  logic              round_i,
  input  logic              sticky_i,
  input  logic [2:0]        mode_i,
  output logic [WORD_W-1:0] result_o,
  output logic              inexact_o,
  output logic              overflow_o
);
  logic              inc;
  logic              to_inf;
  logic [SIG_W-1:0]  sig_r;
  logic [EXPI_W:0]   exp_r;

  fpr_decide u_decide (
    .sign   (sign_i),
    .lsb    (sig_i[0]),
    .guard  (guard_i),
    .rnd    (round_i),
    .sticky (sticky_i),
    .mode   (mode_i),
    .inc    (inc),
    .to_inf (to_inf)
  );

  fpr_incr #(.SIG_W(SIG_W), .EXPI_W(EXPI_W)) u_incr (
    .sig_in  (sig_i),
    .exp_in  (exp_i),
    .inc     (inc),
    .sig_out (sig_r),
    .exp_out (exp_r)
  );

  fpr_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
    .sign     (sign_i),
    .exp_r    (exp_r),
    .frac     (sig_r[FRAC_W-1:0]),
    .to_inf   (to_inf),
    .lost     (guard_i | round_i | sticky_i),
    .word     (result_o),
    .inexact  (inexact_o),
    .overflow (overflow_o)
  );
endmodule

// File: rtl/fp_round_chk.sv
module fp_round_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int EXPI_W = EXP_W + 1,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              sign_i,
  input logic [EXPI_W-1:0] exp_i,
  input logic [SIG_W-1:0]  sig_i,
  input logic              guard_i,
  input logic              round_i,
  input logic              sticky_i,
  input logic [2:0]        mode_i,
  input logic [WORD_W-1:0] result_o,
  input logic              inexact_o,
  input logic              overflow_o
);
  logic              lost;
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  always_comb begin
    lost   = guard_i | round_i | sticky_i;
    exp_f  = result_o[WORD_W-2:FRAC_W];
    frac_f = result_o[FRAC_W-1:0];
    a_r11_sign_kept: assert (result_o[WORD_W-1] == sign_i);
    a_r9_inexact_rule: assert (inexact_o == (lost | overflow_o));
    if (!lost && !overflow_o)
      a_r1_exact_pass: assert (frac_f == sig_i[FRAC_W-1:0] && {1'b0, exp_f} == exp_i);
    if (mode_i == 3'b001 && !overflow_o)
      a_r4_zero_no_incr: assert (frac_f == sig_i[FRAC_W-1:0]);
    if (overflow_o)
      a_r10_saturate: assert (exp_f == {EXP_W{1'b1}} ? frac_f == '0 : (exp_f == {{(EXP_W-1){1'b1}}, 1'b0} && frac_f == '1));
  end
endmodule

bind fp_round_unit fp_round_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
  .sign_i     (sign_i),
  .exp_i      (exp_i),
  .sig_i      (sig_i),
  .guard_i    (guard_i),
  .round_i    (round_i),
  .sticky_i   (sticky_i),
  .mode_i     (mode_i),
  .result_o   (result_o),
  .inexact_o  (inexact_o),
  .overflow_o (overflow_o)
);

// File: tb/fp_round_unit_tb_top.sv
module fp_round_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        sign_i;
  logic [8:0]  exp_i;
  logic [23:0] sig_i;
  logic        guard_i, round_i, sticky_i;
  logic [2:0]  mode_i;
  logic [31:0] result_o;
  logic        inexact_o, overflow_o;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  fp_round_unit dut_i (
    .sign_i(sign_i), .exp_i(exp_i), .sig_i(sig_i),
    .guard_i(guard_i), .round_i(round_i), .sticky_i(sticky_i),
    .mode_i(mode_i), .result_o(result_o),
    .inexact_o(inexact_o), .overflow_o(overflow_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic apply(input string tag, input logic s, input logic [8:0] e,
                       input logic [23:0] sg, input logic [2:0] grs,
                       input logic [2:0] md, input logic [31:0] exp_res,
                       input logic exp_inx, input logic exp_ovf);
    @(posedge clk);
    sign_i = s; exp_i = e; sig_i = sg;
    {guard_i, round_i, sticky_i} = grs;
    mode_i = md;
    @(negedge clk);
    total = total + 1;
    if (result_o !== exp_res || inexact_o !== exp_inx || overflow_o !== exp_ovf) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h/%b/%b expected=%h/%b/%b", tag,
               result_o, inexact_o, overflow_o, exp_res, exp_inx, exp_ovf);
    end
  endtask

  task automatic t_exact();
    apply("R1 exact",       1'b0, 9'd127, 24'hC00000, 3'b000, 3'b000, 32'h3FC00000, 1'b0, 1'b0);
    apply("R1 exact rtz",   1'b1, 9'd1,   24'h800001, 3'b000, 3'b001, 32'h80800001, 1'b0, 1'b0);
  endtask

  task automatic t_even();
    apply("R2 tie lsb0",    1'b0, 9'd127, 24'h800000, 3'b100, 3'b000, 32'h3F800000, 1'b1, 1'b0);
    apply("R2 tie lsb1",    1'b0, 9'd127, 24'h800001, 3'b100, 3'b000, 32'h3F800002, 1'b1, 1'b0);
    apply("R2 above half",  1'b0, 9'd127, 24'h800000, 3'b101, 3'b000, 32'h3F800001, 1'b1, 1'b0);
    apply("R2 below half",  1'b0, 9'd127, 24'h800000, 3'b011, 3'b000, 32'h3F800000, 1'b1, 1'b0);
  endtask

  task automatic t_away();
    apply("R3 tie away",    1'b0, 9'd127, 24'h800000, 3'b100, 3'b100, 32'h3F800001, 1'b1, 1'b0);
    apply("R3 below half",  1'b1, 9'd127, 24'h800000, 3'b011, 3'b100, 32'hBF800000, 1'b1, 1'b0);
  endtask

  task automatic t_zero();
    apply("R4 toward zero", 1'b0, 9'd127, 24'h8FFFFF, 3'b111, 3'b001, 32'h3F8FFFFF, 1'b1, 1'b0);
  endtask

  task automatic t_directed();
    apply("R5 up pos",      1'b0, 9'd127, 24'h800000, 3'b001, 3'b011, 32'h3F800001, 1'b1, 1'b0);
    apply("R5 up neg R11",  1'b1, 9'd127, 24'h800000, 3'b001, 3'b011, 32'hBF800000, 1'b1, 1'b0);
    apply("R6 down neg",    1'b1, 9'd127, 24'h800000, 3'b001, 3'b010, 32'hBF800001, 1'b1, 1'b0);
    apply("R6 down pos",    1'b0, 9'd127, 24'h800000, 3'b111, 3'b010, 32'h3F800000, 1'b1, 1'b0);
  endtask

  task automatic t_spare_codes();
    apply("R7 code7 tie",   1'b0, 9'd127, 24'h800001, 3'b100, 3'b111, 32'h3F800002, 1'b1, 1'b0);
    apply("R7 code5 tie",   1'b0, 9'd127, 24'h800000, 3'b100, 3'b101, 32'h3F800000, 1'b1, 1'b0);
    apply("R7 code6 above", 1'b0, 9'd127, 24'h800000, 3'b110, 3'b110, 32'h3F800001, 1'b1, 1'b0);
  endtask

  task automatic t_carry();
    apply("R8 carry",       1'b0, 9'd127, 24'hFFFFFF, 3'b100, 3'b000, 32'h40000000, 1'b1, 1'b0);
  endtask

  task automatic t_overflow();
    apply("R10 carry inf",  1'b0, 9'd254, 24'hFFFFFF, 3'b100, 3'b000, 32'h7F800000, 1'b1, 1'b1);
    apply("R10 up pos inf", 1'b0, 9'd254, 24'hFFFFFF, 3'b001, 3'b011, 32'h7F800000, 1'b1, 1'b1);
    apply("R10 rtz max",    1'b0, 9'd255, 24'h800000, 3'b000, 3'b001, 32'h7F7FFFFF, 1'b1, 1'b1);
    apply("R10 up neg max", 1'b1, 9'd255, 24'h800000, 3'b000, 3'b011, 32'hFF7FFFFF, 1'b1, 1'b1);
    apply("R10 dn neg inf", 1'b1, 9'd255, 24'h800000, 3'b000, 3'b010, 32'hFF800000, 1'b1, 1'b1);
    apply("R9 ovf inexact", 1'b0, 9'd300, 24'h800000, 3'b000, 3'b100, 32'h7F800000, 1'b1, 1'b1);
    apply("R9 max no ovf",  1'b0, 9'd254, 24'hFFFFFF, 3'b000, 3'b000, 32'h7F7FFFFF, 1'b0, 1'b0);
  endtask

  initial begin
    sign_i = 1'b0; exp_i = 9'd1; sig_i = 24'h800000;
    guard_i = 1'b0; round_i = 1'b0; sticky_i = 1'b0; mode_i = 3'b000;
    t_exact();
    t_even();
    t_away();
    t_zero();
    t_directed();
    t_spare_codes();
    t_carry();
    t_overflow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule